// File: doc/BRIEF.md
# SPI Serial EEPROM Device Model

This block is the device side of a small serial EEPROM that sits on an SPI bus, written so that it can be synthesized. A system clock samples the bus pins (active-low select, serial clock, serial data in). A serial data out pin with a separate output-enable stands in for the tri-state pin. Inside are a byte array of up to 512 entries, a status register, a write-enable latch and a 16-byte page buffer. The internal programming delay is a count of system clocks set by a parameter.

A transaction starts when select falls and ends when it rises. The first byte is an instruction. Reads and writes carry the ninth address bit inside the instruction byte, and the low eight address bits follow in the next byte. A sequential read streams bytes for as long as the host keeps clocking. A page write collects bytes in the page buffer and commits them when select rises. Two status bits fence off part of the array against writes. The SPI pins are plain control pins with no valid/ready flow control, because the host owns the clock and the device can never stall it.

Top module: `spi_eeprom_dev`

## Requirements
- R1: After reset, the output enable is low, the status register reads 00h and every array byte reads FFh.
- R2: READ is 0000_A011b, where A (bit 3) is address bit 8, followed by the low address byte. Input bits are taken on rising serial clock edges. Data leaves MSB first and changes after falling edges. The output enable stays low through the instruction and address bytes.
- R3: A read keeps streaming bytes from successive addresses, and the address wraps from 1FFh to 000h.
- R4: WRITE is 0000_A010b plus the address byte, then data bytes. The address wraps inside its 16-byte page, and the bytes are stored when select rises.
- R5: WREN (06h) sets the write-enable latch and WRDI (04h) clears it. WRITE and WRSR change nothing while the latch is clear.
- R6: If select rises part-way through a data byte, the whole page write is discarded and no write cycle starts.
- R7: RDSR (05h) returns bit 0 as write-in-progress, bit 1 as the write-enable latch, bits 3:2 as the protect field and zero elsewhere. Write-in-progress is 1 for TW_CYCLES clocks after a commit.
- R8: WRSR (01h) plus one data byte updates the protect field from data bits 3:2 only if select rises after exactly 16 clock edges. A 17th edge cancels the update.
- R9: Protect field 01 guards 180h–1FFh, 10 guards 100h–1FFh and 11 guards the whole array. Writes to guarded bytes are dropped, while reads of them still return data.
- R10: While a write cycle runs, every instruction except RDSR is rejected. In particular, a READ keeps the output enable low for the whole transaction.
- R11: The write-enable latch clears when a write cycle completes.
- R12: Raising select in the middle of a read byte ends the read, and the output enable drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_sck | input | 1 | Serial clock from the host |
| spi_mosi | input | 1 | Serial data into the device |
| spi_miso | output | 1 | Serial data out of the device |
| spi_miso_oe | output | 1 | High when spi_miso drives the bus |

## Verification
The bench targets the edges of the commit rules. One WRSR gets a 17th clock edge, which a design that only counts to 16 would wrongly accept. One page write is cut short three bits into a byte, which a design that commits whatever it has collected would store anyway. The page write starts at offset Eh, so a design that carries into the next page writes the wrong byte. A read runs across 1FFh, where a design that stops or saturates returns the wrong byte after the top. A READ is issued during a busy cycle, so a design that serves it would drive the output. The protect field is swept through every guarded range, which catches a design with an off-by-one boundary or one that also blocks reads.

// File: rtl/spie_pkg.sv
package spie_pkg;
  typedef enum logic [2:0] {
    PH_CMD, PH_ADDR, PH_WDATA, PH_SDATA, PH_SDONE, PH_RD, PH_RDSR, PH_IGN
  } phase_t;

  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_WRDI = 8'h04;
  localparam logic [7:0] OP_RDSR = 8'h05;
  localparam logic [7:0] OP_WRSR = 8'h01;
  localparam logic [2:0] OP_RD_LO = 3'b011;
  localparam logic [2:0] OP_WR_LO = 3'b010;
endpackage

// File: rtl/spie_sync.sv
module spie_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck,
  input  logic cs_n,
  input  logic mosi,
  output logic sck_rise,
  output logic sck_fall,
  output logic sel,
  output logic sel_end,
  output logic mosi_s
);
  // bit 2 = sck, bit 1 = cs_n, bit 0 = mosi
  logic [2:0] pipe [STAGES];
  logic       sck_d, sel_d;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe[g] <= 3'b010;
        else if (g == 0) pipe[g] <= {sck, cs_n, mosi};
        else pipe[g] <= pipe[(g == 0) ? 0 : g - 1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_d <= 1'b0;
      sel_d <= 1'b0;
    end else begin
      sck_d <= pipe[STAGES-1][2];
      sel_d <= sel;
    end
  end

  assign sel      = ~pipe[STAGES-1][1];
  assign mosi_s   = pipe[STAGES-1][0];
  assign sck_rise = pipe[STAGES-1][2] & ~sck_d;
  assign sck_fall = ~pipe[STAGES-1][2] & sck_d;
  assign sel_end  = sel_d & ~sel;

  // R2
  edge_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sck_rise |=> !sck_rise);
endmodule

// File: rtl/spie_prot.sv
module spie_prot #(
  parameter int AW = 9
) (
  input  logic [AW-1:0] addr,
  input  logic [1:0]    bp,
  output logic          prot
);
  always_comb begin
    unique case (bp)
      2'b00:   prot = 1'b0;
      2'b01:   prot = &addr[AW-1:AW-2];
      2'b10:   prot = addr[AW-1];
      default: prot = 1'b1;
    endcase
  end
endmodule

// File: rtl/spi_eeprom_dev.sv
module spi_eeprom_dev #(
  parameter int AW        = 9,
  parameter int PAGE_AW   = 4,
  parameter int TW_CYCLES = 500000,
  parameter int SYNC      = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic spi_cs_n,
  input  logic spi_sck,
  input  logic spi_mosi,
  output logic spi_miso,
  output logic spi_miso_oe
);
  import spie_pkg::*;

  localparam int DEPTH = 1 << AW;
  localparam int PAGE  = 1 << PAGE_AW;
  localparam int TWW   = $clog2(TW_CYCLES + 1);
  localparam int CBW   = AW - PAGE_AW;

  logic sck_rise, sck_fall, sel, sel_end, mosi_s;

  spie_sync #(.STAGES(SYNC)) u_sync (
    .clk(clk), .rst_n(rst_n), .sck(spi_sck), .cs_n(spi_cs_n), .mosi(spi_mosi),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .sel(sel), .sel_end(sel_end),
    .mosi_s(mosi_s)
  );

  phase_t             ph;
  logic [7:0]         sr, sdata, osr;
  logic [2:0]         bitpos, ocnt;
  logic               a8, is_rd, have_byte;
  logic [AW-1:0]      addr;
  logic [7:0]         pbuf [PAGE];
  logic [PAGE-1:0]    pmask;
  logic               wel, busy, pg_commit, oe_q, q_q;
  logic [1:0]         bp;
  logic [TWW-1:0]     bcnt;
  logic [CBW-1:0]     cbase;
  logic [7:0]         mem [DEPTH];

  logic [7:0]         nxt, status, obyte;
  logic [8:0]         full_addr;
  logic [PAGE_AW-1:0] cidx;
  logic [AW-1:0]      caddr;
  logic               prot, mem_we;

  assign nxt       = {sr[6:0], mosi_s};
  assign status    = {4'b0000, bp, wel, busy};
  assign full_addr = {a8, nxt};
  assign cidx      = bcnt[PAGE_AW-1:0];
  assign caddr     = {cbase, cidx};
  assign obyte     = (ph == PH_RD) ? mem[addr] : status;

  spie_prot #(.AW(AW)) u_prot (.addr(caddr), .bp(bp), .prot(prot));

  assign mem_we = busy && pg_commit && (bcnt < TWW'(PAGE)) && pmask[cidx] && !prot;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else if (mem_we) begin
      mem[caddr] <= pbuf[cidx];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph <= PH_CMD; sr <= '0; sdata <= '0; osr <= '0; bitpos <= '0; ocnt <= '0;
      a8 <= 1'b0; is_rd <= 1'b0; have_byte <= 1'b0; addr <= '0; pmask <= '0;
      wel <= 1'b0; busy <= 1'b0; pg_commit <= 1'b0; oe_q <= 1'b0; q_q <= 1'b0;
      bp <= '0; bcnt <= '0; cbase <= '0;
      for (int i = 0; i < PAGE; i++) pbuf[i] <= '0;
    end else begin
      // self-timed write cycle
      if (busy) begin
        if (bcnt == TWW'(TW_CYCLES - 1)) begin
          busy <= 1'b0; wel <= 1'b0; pg_commit <= 1'b0;
        end else begin
          bcnt <= bcnt + 1'b1;
        end
      end

      if (!sel) begin
        ph <= PH_CMD; bitpos <= '0; ocnt <= '0; oe_q <= 1'b0;
        if (sel_end && wel && !busy) begin
          if (ph == PH_SDONE) begin
            bp <= sdata[3:2]; busy <= 1'b1; bcnt <= '0;
          end else if (ph == PH_WDATA && bitpos == 3'd0 && have_byte) begin
            busy <= 1'b1; bcnt <= '0; pg_commit <= 1'b1;
            cbase <= addr[AW-1:PAGE_AW];
          end
        end
      end else begin
        if (sck_rise) begin
          sr     <= nxt;
          bitpos <= bitpos + 1'b1;
          if (ph == PH_SDONE) ph <= PH_IGN;
          if (bitpos == 3'd7) begin
            unique case (ph)
              PH_CMD: begin
                if (busy && nxt != OP_RDSR) ph <= PH_IGN;
                else if (nxt == OP_WREN) begin wel <= 1'b1; ph <= PH_IGN; end
                else if (nxt == OP_WRDI) begin wel <= 1'b0; ph <= PH_IGN; end
                else if (nxt == OP_RDSR) ph <= PH_RDSR;
                else if (nxt == OP_WRSR) ph <= PH_SDATA;
                else if (nxt[7:4] == 4'h0 && nxt[2:0] == OP_RD_LO) begin
                  a8 <= nxt[3]; is_rd <= 1'b1; ph <= PH_ADDR;
                end else if (nxt[7:4] == 4'h0 && nxt[2:0] == OP_WR_LO) begin
                  a8 <= nxt[3]; is_rd <= 1'b0; ph <= PH_ADDR;
                end else ph <= PH_IGN;
              end
              PH_ADDR: begin
                addr <= full_addr[AW-1:0];
                if (is_rd) ph <= PH_RD;
                else begin
                  ph <= PH_WDATA; pmask <= '0; have_byte <= 1'b0;
                end
              end
              PH_WDATA: begin
                pbuf[addr[PAGE_AW-1:0]]  <= nxt;
                pmask[addr[PAGE_AW-1:0]] <= 1'b1;
                addr[PAGE_AW-1:0]        <= addr[PAGE_AW-1:0] + 1'b1;
                have_byte                <= 1'b1;
              end
              PH_SDATA: begin sdata <= nxt; ph <= PH_SDONE; end
              default: ;
            endcase
          end
        end
        if (sck_fall && (ph == PH_RD || ph == PH_RDSR)) begin
          oe_q <= 1'b1;
          if (ocnt == 3'd0) begin
            q_q  <= obyte[7];
            osr  <= {obyte[6:0], 1'b0};
            ocnt <= 3'd7;
            if (ph == PH_RD) addr <= addr + 1'b1;
          end else begin
            q_q  <= osr[7];
            osr  <= {osr[6:0], 1'b0};
            ocnt <= ocnt - 1'b1;
          end
        end
      end
    end
  end

  assign spi_miso    = q_q;
  assign spi_miso_oe = oe_q;

  // R11
  wel_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !wel);
  // R5
  wel_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wel));
  // R8
  bp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(bp) |-> $rose(busy));
  // R10
  rd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_RD) |-> !busy);
  // R12
  oe_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> !spi_miso_oe);
  // R9
  we_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (busy && $stable(bp)));
endmodule

// File: tb/spi_eeprom_dev_bench.sv
module spi_eeprom_dev_bench;
  localparam int TW = 400;
  localparam int H  = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, sck = 1'b0, mosi = 1'b0;
  logic miso, miso_oe;
  int   n_chk = 0, n_err = 0;
  logic [7:0] last_rx;
  logic       last_oe;
  logic [7:0] v;

  always #10 clk = ~clk;

  spi_eeprom_dev #(.TW_CYCLES(TW)) u_spi_eeprom_dev (
    .clk(clk), .rst_n(rst_n), .spi_cs_n(cs_n), .spi_sck(sck), .spi_mosi(mosi),
    .spi_miso(miso), .spi_miso_oe(miso_oe)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic hw(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic spi_bits(input logic [7:0] tx, input int n);
    last_oe = 1'b0;
    for (int i = n - 1; i >= 0; i--) begin
      mosi = tx[i];
      hw(H);
      last_rx[i] = miso;
      if (miso_oe) last_oe = 1'b1;
      sck = 1'b1;
      hw(H);
      sck = 1'b0;
    end
  endtask

  task automatic spi_byte(input logic [7:0] tx);
    spi_bits(tx, 8);
  endtask

  task automatic cs_lo();
    cs_n = 1'b0; hw(H);
  endtask

  task automatic cs_hi();
    hw(H); cs_n = 1'b1; hw(2 * H);
  endtask

  task automatic wait_wc();
    hw(TW + 50);
  endtask

  task automatic one_op(input logic [7:0] op);
    cs_lo(); spi_byte(op); cs_hi();
  endtask

  task automatic rdsr(output logic [7:0] s);
    cs_lo(); spi_byte(8'h05); spi_byte(8'h00); s = last_rx; cs_hi();
  endtask

  task automatic write1(input logic [8:0] a, input logic [7:0] d);
    one_op(8'h06);
    cs_lo(); spi_byte({4'h0, a[8], 3'b010}); spi_byte(a[7:0]); spi_byte(d); cs_hi();
    wait_wc();
  endtask

  task automatic read1(input logic [8:0] a, output logic [7:0] d);
    cs_lo(); spi_byte({4'h0, a[8], 3'b011}); spi_byte(a[7:0]); spi_byte(8'h00);
    d = last_rx; cs_hi();
  endtask

  task automatic set_bp(input logic [1:0] b);
    one_op(8'h06);
    cs_lo(); spi_byte(8'h01); spi_byte({4'h0, b, 2'b00}); cs_hi();
    wait_wc();
  endtask

  task automatic t_reset();
    chk("R1 oe", miso_oe, 0);
    rdsr(v); chk("R1 status", v, 8'h00);
    read1(9'h123, v); chk("R1 array", v, 8'hFF);
  endtask

  task automatic t_write_read();
    logic ao;
    one_op(8'h06);
    rdsr(v); chk("R7 wel", v, 8'h02);
    cs_lo(); spi_byte(8'h0A); spi_byte(8'h05);
    spi_byte(8'hAA); spi_byte(8'h55); spi_byte(8'h3C); cs_hi();
    rdsr(v); chk("R7 wip", v, 8'h03);
    wait_wc();
    rdsr(v); chk("R11 wel clear", v, 8'h00);
    cs_lo(); spi_byte(8'h0B); ao = last_oe; spi_byte(8'h05); ao = ao | last_oe;
    chk("R2 hi-z during cmd/addr", ao, 0);
    spi_byte(8'h00); chk("R2 byte0", last_rx, 8'hAA); chk("R2 oe", last_oe, 1);
    spi_byte(8'h00); chk("R2 byte1", last_rx, 8'h55);
    spi_byte(8'h00); chk("R2 byte2", last_rx, 8'h3C);
    cs_hi();
  endtask

  task automatic t_page_wrap();
    one_op(8'h06);
    cs_lo(); spi_byte(8'h02); spi_byte(8'h0E);
    spi_byte(8'h11); spi_byte(8'h22); spi_byte(8'h33); cs_hi();
    wait_wc();
    read1(9'h00E, v); chk("R4 0E", v, 8'h11);
    read1(9'h00F, v); chk("R4 0F", v, 8'h22);
    read1(9'h000, v); chk("R4 wrap 00", v, 8'h33);
    read1(9'h010, v); chk("R4 next page untouched", v, 8'hFF);
  endtask

  task automatic t_read_wrap();
    write1(9'h1FF, 8'h77);
    cs_lo(); spi_byte(8'h0B); spi_byte(8'hFF);
    spi_byte(8'h00); chk("R3 1FF", last_rx, 8'h77);
    spi_byte(8'h00); chk("R3 wrap 000", last_rx, 8'h33);
    spi_byte(8'h00); chk("R3 001", last_rx, 8'hFF);
    cs_hi();
  endtask

  task automatic t_no_wel();
    one_op(8'h06); one_op(8'h04);
    rdsr(v); chk("R5 wrdi", v, 8'h00);
    cs_lo(); spi_byte(8'h02); spi_byte(8'h50); spi_byte(8'h99); cs_hi();
    rdsr(v); chk("R5 no cycle", v, 8'h00);
    read1(9'h050, v); chk("R5 unchanged", v, 8'hFF);
  endtask

  task automatic t_partial();
    one_op(8'h06);
    cs_lo(); spi_byte(8'h02); spi_byte(8'h60); spi_byte(8'hAB); spi_bits(8'h05, 3); cs_hi();
    rdsr(v); chk("R6 no cycle", v, 8'h02);
    read1(9'h060, v); chk("R6 discarded", v, 8'hFF);
    one_op(8'h04);
  endtask

  task automatic t_wrsr();
    one_op(8'h06);
    cs_lo(); spi_byte(8'h01); spi_byte(8'h04); spi_bits(8'h01, 1); cs_hi();
    rdsr(v); chk("R8 17 clocks", v, 8'h02);
    cs_lo(); spi_byte(8'h01); spi_byte(8'h04); cs_hi();
    rdsr(v); chk("R8 busy after 16", v, 8'h07);
    wait_wc();
    rdsr(v); chk("R8 bp set", v, 8'h04);
  endtask

  task automatic t_protect();
    write1(9'h180, 8'h12); read1(9'h180, v); chk("R9 q3 blocked", v, 8'hFF);
    write1(9'h17F, 8'h34); read1(9'h17F, v); chk("R9 below q3", v, 8'h34);
    read1(9'h1FF, v); chk("R9 read guarded", v, 8'h77);
    set_bp(2'b10);
    write1(9'h100, 8'h56); read1(9'h100, v); chk("R9 half blocked", v, 8'hFF);
    write1(9'h0FF, 8'h78); read1(9'h0FF, v); chk("R9 below half", v, 8'h78);
    set_bp(2'b11);
    write1(9'h001, 8'h9A); read1(9'h001, v); chk("R9 all blocked", v, 8'hFF);
    set_bp(2'b00);
    rdsr(v); chk("R9 bp cleared", v, 8'h00);
  endtask

  task automatic t_busy_read();
    logic ao;
    one_op(8'h06);
    cs_lo(); spi_byte(8'h02); spi_byte(8'h20); spi_byte(8'h5A); cs_hi();
    cs_lo(); spi_byte(8'h03); ao = last_oe; spi_byte(8'h20); ao = ao | last_oe;
    spi_byte(8'h00); ao = ao | last_oe; cs_hi();
    chk("R10 read rejected", ao, 0);
    wait_wc();
    read1(9'h020, v); chk("R10 later read", v, 8'h5A);
  endtask

  task automatic t_abort();
    cs_lo(); spi_byte(8'h0B); spi_byte(8'h05);
    spi_byte(8'h00); chk("R12 first", last_rx, 8'hAA);
    spi_bits(8'h00, 4);
    cs_n = 1'b1; hw(H);
    chk("R12 oe off", miso_oe, 0);
    hw(H);
    read1(9'h106, v); chk("R12 next read", v, 8'h55);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog R1-timeout: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    hw(5); rst_n = 1'b1; hw(5);
    t_reset();
    t_write_read();
    t_page_wrap();
    t_read_wrap();
    t_no_wel();
    t_partial();
    t_wrsr();
    t_protect();
    t_busy_read();
    t_abort();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule